// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter

This block is a synchronous binary counter, twelve bits wide by default, that steps up or down by one on each rising clock edge while its active-low run input is asserted. A parallel value can be preset into it on a clock edge. An active-low clear empties it at once, without waiting for the clock. The count register drives the value output directly.

The three controls follow a fixed order. Clear wins over everything. Preset wins over counting. The run input has no effect on preset or clear. When the count passes its end value it wraps around: all ones goes to zero when stepping up, and zero goes to all ones when stepping down. A terminal flag is decoded from the present value, the direction and the run input. It lets surrounding logic see that the next counting edge will wrap.

Top module: `updn_preset_counter`

## Requirements
- R1: While arst_n is low, count_q reads zero, and it becomes zero without any clock edge.
- R2: If arst_n and pload_n are both low at a clock edge, count_q stays zero, so clear overrides preset.
- R3: If pload_n is low at a rising clock edge while arst_n is high, count_q takes the value of par_in after that edge.
- R4: A preset takes effect whether run_n is high or low.
- R5: If pload_n and run_n are both low at an edge, count_q takes par_in and does not count.
- R6: With pload_n high, run_n low and dir_up high, each edge increases count_q by one.
- R7: With pload_n high, run_n low and dir_up low, each edge decreases count_q by one.
- R8: When counting up, all ones (4095 at the default width) wraps to zero.
- R9: When counting down, zero wraps to all ones.
- R10: With pload_n high and run_n high, count_q keeps its value across edges.
- R11: term_o is high exactly when run_n is low and count_q equals the end value for the current direction: all ones if dir_up is high, zero if dir_up is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Asynchronous clear, active low |
| pload_n | input | 1 | Synchronous preset, active low |
| run_n | input | 1 | Count enable, active low |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| par_in | input | WIDTH | Preset value |
| count_q | output | WIDTH | Present count |
| term_o | output | 1 | End-of-sequence flag for the current direction |

## Verification
The clocked properties assume that pload_n, run_n, dir_up and par_in are stable around each rising edge. They also assume that a clear is either held across the edges they span or aborts them through the disable condition. The bench changes every input two time units after a rising edge, and it pulls the clear low only in the middle of a cycle. Because of this, each property sees a value that is settled at both of its edges. The wrap properties rely on the terminal flag being decoded from the same control values that choose the step. The bench holds those controls steady through each wrap.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/updn_cnt_ctrl.sv
module updn_cnt_ctrl
  import updn_cnt_pkg::*;
(
  input  logic    pload_n,
  input  logic    run_n,
  input  logic    dir_up,
  output cnt_op_e op_o
);
  // Preset outranks counting; run_n only matters when no preset is pending.
  always_comb begin
    if (!pload_n)      op_o = OP_LOAD;
    else if (run_n)    op_o = OP_HOLD;
    else if (dir_up)   op_o = OP_INC;
    else               op_o = OP_DEC;
  end
endmodule

// File: rtl/updn_cnt_next.sv
module updn_cnt_next
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // Modular arithmetic gives both wrap points for free.
  always_comb begin
    unique case (op_i)
      OP_LOAD: nxt_o = par_i;
      OP_INC:  nxt_o = cur_i + ONE;
      OP_DEC:  nxt_o = cur_i - ONE;
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/updn_cnt_term.sv
module updn_cnt_term #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             run_n,
  input  logic             dir_up,
  output logic             term_o
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  logic at_top, at_bot;
  assign at_top = (cur_i == TOP_VAL);
  assign at_bot = (cur_i == BOT_VAL);
  assign term_o = !run_n && (dir_up ? at_top : at_bot);
endmodule

// File: rtl/updn_preset_counter.sv
module updn_preset_counter
  import updn_cnt_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             pload_n,
  input  logic             run_n,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] count_q,
  output logic             term_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  cnt_op_e          op;
  logic [WIDTH-1:0] cnt_nxt;

  updn_cnt_ctrl u_ctrl (
    .pload_n (pload_n),
    .run_n   (run_n),
    .dir_up  (dir_up),
    .op_o    (op)
  );

  updn_cnt_next #(.WIDTH(WIDTH)) u_next (
    .op_i  (op),
    .cur_i (count_q),
    .par_i (par_in),
    .nxt_o (cnt_nxt)
  );

  updn_cnt_term #(.WIDTH(WIDTH)) u_term (
    .cur_i  (count_q),
    .run_n  (run_n),
    .dir_up (dir_up),
    .term_o (term_o)
  );

  // Clear has top priority through the asynchronous reset of the register.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) count_q <= '0;
    else         count_q <= cnt_nxt;
  end

  // R3 / R4 / R5: preset lands on the next edge regardless of run_n
  p_preset_r3: assert property (@(posedge clk) disable iff (!arst_n)
    !pload_n |=> count_q == $past(par_in));

  // R10: hold when idle
  p_hold_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (pload_n && run_n) |=> $stable(count_q));

  // R6: upward step
  p_inc_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (pload_n && !run_n && dir_up) |=> count_q == WIDTH'($past(count_q) + WIDTH'(1)));

  // R7: downward step
  p_dec_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (pload_n && !run_n && !dir_up) |=> count_q == WIDTH'($past(count_q) - WIDTH'(1)));

  // R11: flag only while running
  p_term_gate_r11: assert property (@(posedge clk) disable iff (!arst_n)
    term_o |-> !run_n);

  // R8: flag while stepping up predicts wrap to zero
  p_wrap_up_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (term_o && dir_up && pload_n) |=> count_q == '0);

  // R9: flag while stepping down predicts wrap to all ones
  p_wrap_dn_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (term_o && !dir_up && pload_n) |=> count_q == ALL_ONES);
endmodule

// File: tb/updn_preset_counter_tb_top.sv
module updn_preset_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         arst_n;
  logic         pload_n;
  logic         run_n;
  logic         dir_up;
  logic [W-1:0] par_in;
  logic [W-1:0] count_q;
  logic         term_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_preset_counter #(.WIDTH(W)) dut_i (
    .clk     (clk),
    .arst_n  (arst_n),
    .pload_n (pload_n),
    .run_n   (run_n),
    .dir_up  (dir_up),
    .par_in  (par_in),
    .count_q (count_q),
    .term_o  (term_o)
  );

  task automatic chk_cnt(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (count_q !== exp) begin
      n_bad++;
      $display("FIL%s %s: count_q actual %0d expected %0d", "", req, count_q, exp);
    end
  endtask

  task automatic chk_term(input string req, input logic exp);
    n_chk++;
    if (term_o !== exp) begin
      n_bad++;
      $display("FAIL %s: term_o actual %0b expected %0b", req, term_o, exp);
    end
  endtask

  // one edge, then settle away from it
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_load(input logic [W-1:0] v, input logic rn);
    pload_n = 1'b0; run_n = rn; par_in = v;
    step();
    pload_n = 1'b1;
  endtask

  task automatic t_reset();
    chk_cnt("R1", '0);
    chk_term("R11", 1'b0);
    step();
    chk_cnt("R1", '0);
    arst_n = 1'b1;
    step();
  endtask

  task automatic t_load_while_idle();
    do_load(12'h5A3, 1'b1);
    chk_cnt("R3 R4", 12'h5A3);
    step(); step();
    chk_cnt("R10", 12'h5A3);
    chk_term("R11", 1'b0);
  endtask

  task automatic t_up_wrap();
    do_load(12'hFFD, 1'b1);
    dir_up = 1'b1; run_n = 1'b0;
    step(); chk_cnt("R6", 12'hFFE); chk_term("R11", 1'b0);
    step(); chk_cnt("R6", MAXV);    chk_term("R11", 1'b1);
    step(); chk_cnt("R8", '0);      chk_term("R11", 1'b0);
    step(); chk_cnt("R6", 12'h001);
    run_n = 1'b1;
  endtask

  task automatic t_term_idle();
    do_load(MAXV, 1'b1);
    dir_up = 1'b1;
    #1; chk_term("R11", 1'b0);
    dir_up = 1'b0;
    #1; chk_term("R11", 1'b0);
    run_n = 1'b0;
    #1; chk_term("R11", 1'b0);
    dir_up = 1'b1;
    #1; chk_term("R11", 1'b1);
    run_n = 1'b1;
  endtask

  task automatic t_down_wrap();
    do_load(12'h002, 1'b1);
    dir_up = 1'b0; run_n = 1'b0;
    step(); chk_cnt("R7", 12'h001); chk_term("R11", 1'b0);
    step(); chk_cnt("R7", '0);      chk_term("R11", 1'b1);
    step(); chk_cnt("R9", MAXV);    chk_term("R11", 1'b0);
    step(); chk_cnt("R7", 12'hFFE);
    run_n = 1'b1;
  endtask

  task automatic t_load_over_count();
    dir_up = 1'b1;
    do_load(12'h123, 1'b0);
    chk_cnt("R5", 12'h123);
    step();
    chk_cnt("R6", 12'h124);
    run_n = 1'b1;
  endtask

  task automatic t_async_clear();
    do_load(12'h777, 1'b1);
    #3;
    arst_n = 1'b0;
    #1;
    chk_cnt("R1", '0);
    pload_n = 1'b0; par_in = 12'hABC; run_n = 1'b0;
    step();
    chk_cnt("R2", '0);
    pload_n = 1'b1; run_n = 1'b1;
    arst_n = 1'b1;
    step();
    chk_cnt("R1", '0);
  endtask

  initial begin
    arst_n = 1'b0; pload_n = 1'b1; run_n = 1'b1; dir_up = 1'b1; par_in = '0;
    #3;
    t_reset();
    t_load_while_idle();
    t_up_wrap();
    t_term_idle();
    t_down_wrap();
    t_load_over_count();
    t_async_clear();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule